// File: doc/BRIEF.md
# Two-Stage I2C Bus Clock Prescaler

This block turns a fast core clock into the timing grid for an I2C master's bit engine. Two programmable divider stages are chained. The first stage counts core cycles. Each time it wraps, it advances the second stage. When both stages wrap together, the block emits one base tick. Twenty-two base ticks make one SCL period. The SCL frequency is therefore the core clock divided by 22 × (A+1) × (B+1), where A and B are the two divisor fields. With a suitable core clock, the range reaches the 400 kHz fast-mode rate.

The divisor fields are read from a control word. While a transfer runs, the block copies the fields into working registers only at the end of an SCL period. A field rewrite in the middle of a period therefore never shortens or stretches a clock half. While the master is idle, the counters are held cleared, so the first SCL low phase after the start is full width. Alongside the SCL level, the block emits four phase strobes. These mark when SCL should fall, when SDA may change (the middle of the low half), when SCL should rise, and when SDA should be sampled (the middle of the high half).

Top module: `scl_clk_div`

## Requirements
- R1: While `run_i` is high, `tick_o` pulses for exactly one core cycle every (A+1)×(B+1) cycles. The first pulse falls in cycle (A+1)×(B+1)−1, counted from the first cycle in which `run_i` is high (cycle 0).
- R2: A is taken from control bits 15:14 and B from control bits 13:8. Bits 7:0 of the control word have no effect on any output.
- R3: Number the base ticks of a period 0 to 21. `scl_o` is low for the 11 tick intervals of ticks 0 to 10 and high for those of ticks 11 to 21. `scl_o` is 1 whenever `run_i` is low.
- R4: `sda_o` pulses together with tick 4, so that SDA changes at the midpoint of the low half.
- R5: `rise_o` pulses with tick 10, `samp_o` with tick 15, and `fall_o` with tick 21, which is the last tick of the period. At most one of the four strobes is high in any cycle, and every strobe coincides with a `tick_o` pulse.
- R6: When the divisor fields change while `run_i` is high, the current period finishes with the old values. The new values apply from the cycle after the `fall_o` pulse.
- R7: While `run_i` is low, no tick or strobe is produced and the counters are cleared. When `run_i` rises, the first period starts from cycle 0 with full-width timing and uses the divisor fields present in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | Master active; low holds the prescaler cleared |
| ctrl_i | input | 16 | Control word carrying divisor A (15:14) and divisor B (13:8) |
| tick_o | output | 1 | Base tick, one core cycle wide |
| fall_o | output | 1 | Strobe: end of period, SCL goes low next |
| sda_o | output | 1 | Strobe: midpoint of SCL low, SDA may change |
| rise_o | output | 1 | Strobe: SCL goes high next |
| samp_o | output | 1 | Strobe: midpoint of SCL high, sample SDA |
| scl_o | output | 1 | SCL level for the pad driver |

## Verification
The tick and the strobes are combinational from the counter state and `run_i`, so each is due in the same cycle it is predicted for. Tick n of a period that starts at cycle s appears in cycle s+(n+1)×P−1, where P = (A+1)×(B+1). `scl_o` comes from the registered slot counter and changes in the cycle after a rise or fall strobe. It changes at once when `run_i` changes. The driver computes the absolute cycle of every expected pulse and pushes it into a queue. For a mid-period field change, it uses the old P up to the period boundary and the new P after it. The monitor samples on the falling clock edge against a shared cycle counter. In every cycle, it demands either the queued pulse pattern or complete silence.

// File: rtl/scl_div_pkg.sv
// Package: scl_div_pkg
// Shared constants and types for the two-stage SCL prescaler.
// Assumes a period of 22 base ticks split evenly into low and high halves.
package scl_div_pkg;

    localparam int TICKS_PER_PERIOD = 22;
    localparam int HALF_TICKS       = TICKS_PER_PERIOD / 2;
    localparam int SLOT_W           = $clog2(TICKS_PER_PERIOD);

    // Slot index (before increment) on whose tick each strobe fires.
    localparam int SDA_SLOT  = HALF_TICKS / 2 - 1;                 // 4
    localparam int RISE_SLOT = HALF_TICKS - 1;                     // 10
    localparam int SAMP_SLOT = HALF_TICKS + HALF_TICKS / 2 - 1;    // 15
    localparam int FALL_SLOT = TICKS_PER_PERIOD - 1;               // 21

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic fall;
        logic samp;
        logic rise;
        logic sda;
    } phase_strobe_t;

endpackage

// File: rtl/scl_prescale_stage.sv
// Module: scl_prescale_stage
// One wrap-around counter stage. It advances on each step. It signals a wrap
// in the step cycle in which the count equals the limit. Each stage thus
// divides its step rate by (limit+1).
// Assumes the limit changes only while the count is zero (idle or at a wrap).
module scl_prescale_stage #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         wrap_o
);

    logic [W-1:0] cnt_q;
    logic         at_limit;

    // Terminal-count compare and wrap qualification.
    always_comb begin
        at_limit = (cnt_q == limit);
        wrap_o   = step && at_limit;
    end

    // Count steps, return to zero at the limit, hold cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end

    // R1: the count never passes the programmed limit
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    // R7: a clear leaves the counter at zero
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/scl_phase_seq.sv
// Module: scl_phase_seq
// Tracks the position (slot 0..21) of the current SCL period on each base
// tick. Decodes the four phase strobes and the SCL half.
// Assumes each tick is a single-cycle pulse from the prescaler chain.
module scl_phase_seq
    import scl_div_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output phase_strobe_t strobe_o,
    output logic          high_half_o
);

    slot_t slot_q;
    logic  last_slot;

    // Decode the strobes from the slot that the current tick completes.
    always_comb begin
        last_slot     = (slot_q == slot_t'(FALL_SLOT));
        strobe_o.sda  = tick && (slot_q == slot_t'(SDA_SLOT));
        strobe_o.rise = tick && (slot_q == slot_t'(RISE_SLOT));
        strobe_o.samp = tick && (slot_q == slot_t'(SAMP_SLOT));
        strobe_o.fall = tick && last_slot;
        high_half_o   = (slot_q >= slot_t'(HALF_TICKS));
    end

    // Advance the slot on each tick and wrap at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            slot_q <= '0;
        end else if (tick) begin
            slot_q <= last_slot ? '0 : slot_q + 1'b1;
        end
    end

    // R3: the slot stays within one period
    p_slot_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= slot_t'(FALL_SLOT));

    // R5: never two strobes at once
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_o));

    // R5: strobes only ride on a tick
    p_strobe_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o != '0) |-> tick);

    // R7: idle clears the period position
    p_idle_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (slot_q == '0));

endmodule

// File: rtl/scl_clk_div.sv
// Module: scl_clk_div (top)
// Two-stage SCL prescaler. Stage A divides the core clock by (A+1). Stage B
// divides the stage A wraps by (B+1). The phase sequencer turns 22 base ticks
// into one SCL period with four phase strobes. The divisor fields are
// captured into working copies while idle and at each period boundary.
// Assumes run_i is synchronous to clk and that field bit positions are fixed
// by the parameters.
module scl_clk_div
    import scl_div_pkg::*;
#(
    parameter int CTRL_W   = 16,
    parameter int DIVA_LSB = 14,
    parameter int DIVA_W   = 2,
    parameter int DIVB_LSB = 8,
    parameter int DIVB_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              tick_o,
    output logic              fall_o,
    output logic              sda_o,
    output logic              rise_o,
    output logic              samp_o,
    output logic              scl_o
);

    logic [DIVA_W-1:0] fld_a, work_a, eff_a;
    logic [DIVB_W-1:0] fld_b, work_b, eff_b;
    logic              active_q;
    logic              stage_a_wrap;
    logic              base_tick;
    logic              high_half;
    logic              boundary;
    phase_strobe_t     strobe;

    // Extract the fields and pick live or captured divisors.
    always_comb begin
        fld_a = ctrl_i[DIVA_LSB +: DIVA_W];
        fld_b = ctrl_i[DIVB_LSB +: DIVB_W];
        eff_a = active_q ? work_a : fld_a;
        eff_b = active_q ? work_b : fld_b;
    end

    // Track activity and capture divisors while idle or at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            work_a   <= '0;
            work_b   <= '0;
        end else begin
            active_q <= run_i;
            if (!active_q || boundary) begin
                work_a <= fld_a;
                work_b <= fld_b;
            end
        end
    end

    scl_prescale_stage #(.W(DIVA_W)) u_stage_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!run_i),
        .step   (run_i),
        .limit  (eff_a),
        .wrap_o (stage_a_wrap)
    );

    scl_prescale_stage #(.W(DIVB_W)) u_stage_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!run_i),
        .step   (stage_a_wrap),
        .limit  (eff_b),
        .wrap_o (base_tick)
    );

    scl_phase_seq u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (!run_i),
        .tick        (base_tick),
        .strobe_o    (strobe),
        .high_half_o (high_half)
    );

    // Drive the outputs; SCL idles high.
    always_comb begin
        boundary = strobe.fall;
        tick_o   = base_tick;
        fall_o   = strobe.fall;
        sda_o    = strobe.sda;
        rise_o   = strobe.rise;
        samp_o   = strobe.samp;
        scl_o    = run_i ? high_half : 1'b1;
    end

    // R6: working divisors hold between boundaries during a transfer
    p_divisor_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && run_i && !boundary) |=> ($stable(work_a) && $stable(work_b)));

    // R3: a rising SCL during a transfer follows a rise strobe
    p_rise_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && $rose(scl_o)) |-> $past(rise_o));

    // R7: no tick while idle
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !tick_o);

    // R3: SCL high while idle
    p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> scl_o);

endmodule

// File: tb/scl_clk_div_bench.sv
module scl_clk_div_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic [15:0] ctrl_i = 16'h0000;
    logic        tick_o, fall_o, sda_o, rise_o, samp_o, scl_o;

    typedef struct {
        int       cyc;
        logic [4:0] code;   // {tick, sda, rise, samp, fall}
    } exp_t;

    exp_t  expq[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    string case_tag = "R7";
    logic  exp_scl = 1'b1;
    logic  run_prev = 1'b0;
    bit    done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    scl_clk_div u_scl_clk_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_i),
        .ctrl_i (ctrl_i),
        .tick_o (tick_o),
        .fall_o (fall_o),
        .sda_o  (sda_o),
        .rise_o (rise_o),
        .samp_o (samp_o),
        .scl_o  (scl_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] mk_ctrl(int a, int b, bit junk);
        logic [15:0] w;
        w = '0;
        w[15:14] = a[1:0];
        w[13:8]  = b[5:0];
        if (junk) w[7:0] = 8'hFF;   // R2: low bits must be ignored
        return w;
    endfunction

    // Queue the expected pulses of one full or truncated run.
    task automatic push_period(int base, int p, int c0, int cut);
        for (int s = 0; s < 22; s++) begin
            exp_t e;
            int rel;
            rel = base + (s + 1) * p - 1;
            if (rel < cut) begin
                e.cyc  = c0 + rel;
                e.code = {1'b1, s == 4, s == 10, s == 15, s == 21};
                expq.push_back(e);
            end
        end
    endtask

    // Driver: runs one case with an optional mid-period field change.
    task automatic run_case(string tag, int a1, int b1, int a2, int b2,
                            bit junk, int chg_at, int nper, int cut_req);
        int p1, p2, total, cut, c0, base;
        p1 = (a1 + 1) * (b1 + 1);
        p2 = (a2 + 1) * (b2 + 1);
        total = 22 * p1 + (nper - 1) * 22 * p2;
        cut = (cut_req > 0) ? cut_req : total;
        @(posedge clk); #1;
        case_tag = tag;
        c0 = cyc;
        base = 0;
        for (int k = 0; k < nper; k++) begin
            push_period(base, (k == 0) ? p1 : p2, c0, cut);
            base += 22 * ((k == 0) ? p1 : p2);
        end
        ctrl_i = mk_ctrl(a1, b1, junk);
        run_i = 1'b1;
        for (int r = 1; r < cut; r++) begin
            @(posedge clk); #1;
            if (r == chg_at) ctrl_i = mk_ctrl(a2, b2, junk);
        end
        @(posedge clk); #1;
        run_i = 1'b0;
        case_tag = "R7";
        ctrl_i = mk_ctrl(3, 17, 1'b1);   // R7: idle field churn, no effect
        repeat (25) @(posedge clk);
    endtask

    // Monitor: compares pulses and SCL level each cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [4:0] obs, want;
            obs = {tick_o, sda_o, rise_o, samp_o, fall_o};
            if (!run_i) exp_scl = 1'b1;
            else if (!run_prev) exp_scl = 1'b0;
            checks++;
            if (scl_o !== exp_scl) begin
                errors++;
                $display("FAIL R3 (%s) cyc %0d scl: actual %b expected %b",
                         case_tag, cyc, scl_o, exp_scl);
            end
            want = 5'b0;
            if (expq.size() > 0 && expq[0].cyc == cyc) begin
                want = expq[0].code;
                void'(expq.pop_front());
            end
            checks++;
            if (obs !== want) begin
                errors++;
                $display("FAIL %s cyc %0d pulses {tick,sda,rise,samp,fall}: actual %b expected %b (R1/R4/R5)",
                         case_tag, cyc, obs, want);
            end
            if (want[2]) exp_scl = 1'b1;
            if (want[0]) exp_scl = 1'b0;
            run_prev = run_i;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;   // R7 reset state
        if (scl_o !== 1'b1 || tick_o !== 1'b0) begin
            errors++;
            $display("FAIL R7 reset: actual scl %b tick %b expected 1 0", scl_o, tick_o);
        end
        run_case("R1", 0, 0, 0, 0, 1'b0, -1, 2, 0);     // fastest, P=1
        run_case("R4", 1, 2, 1, 2, 1'b0, -1, 2, 0);     // P=6
        run_case("R2", 2, 1, 2, 1, 1'b1, -1, 1, 0);     // junk low bits
        run_case("R6", 0, 1, 2, 0, 1'b1, 10, 3, 0);     // change mid-period
        run_case("R6", 1, 0, 0, 0, 1'b0, 30, 2, 0);     // shrink at boundary
        run_case("R7", 1, 1, 1, 1, 1'b0, -1, 1, 37);    // stop inside low half
        run_case("R7", 1, 1, 1, 1, 1'b0, -1, 1, 0);     // restart full width
        run_case("R5", 3, 63, 3, 63, 1'b0, -1, 1, 0);   // largest divisors
        repeat (5) @(posedge clk);
        done = 1'b1;
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R1 leftover pulses: actual %0d expected 0", expq.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule